// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host offers one access at a time over a valid/ready handshake: an 18-bit word address, a read/write flag, write data and a two-bit byte-lane mask. The block turns each access into a sequence of registered, active-low strobes on the RAM: chip select, output enable, write strobe and one select per byte lane. It also drives the 16-bit data bus through a separate output-enable, since the bus is shared with the RAM.

Each timing phase has a length in clock cycles. The block computes it at elaboration from a nanosecond minimum and the clock period parameter, rounding up, with a floor of one cycle. A read holds its strobes for the access time and then latches the bus. A write holds the write strobe low for the longest of the pulse-width, address-to-end and data-to-end minimums, and keeps data on the bus for one cycle after the strobe rises. When a write comes straight after a read, the block first waits for the RAM to release the bus. Completion of every access is signalled by a single-cycle done pulse.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held, and whenever no access is in progress, chip select, output enable, write strobe and both lane selects are high, the data bus drive is off, `req_ready` is high and `rsp_done` is low.
- R2: An accepted read drives chip select and output enable low with the write strobe high for RD_CYC = ceil(85 ns / clock period) cycles, which is 9 at a 10 ns clock. On the edge that ends that count the bus is latched into `rsp_rdata`, and `rsp_done` is high in the following cycle.
- R3: `req_be` bit 0 selects data bits 7:0 and drives `sram_lb_n` low; bit 1 selects bits 15:8 and drives `sram_ub_n` low. This holds for reads and writes. In read data, a byte whose lane was not selected is returned as zero, and a write leaves unselected bytes of the RAM word unchanged.
- R4: An accepted write holds chip select and the write strobe low, output enable high and the data bus driven for WR_CYC cycles. WR_CYC is the largest of ceil(65 ns), ceil(75 ns), ceil(35 ns) and ceil(85 ns minus one clock), each divided by the clock period; at 10 ns this gives 8. Chip select and the write strobe then rise together, and the same data stays driven for one more cycle, in which `rsp_done` is high.
- R5: A write accepted directly after a read first spends TURN_CYC = ceil(25 ns / clock period) cycles (3 at 10 ns) with chip select low, output enable high, the write strobe high and the bus drive off. A write that follows a write, or the first access after reset, has no such wait.
- R6: `rsp_done` is high for exactly one cycle per accepted request. `req_ready` is high only when no access is in progress. The address presented to the RAM stays constant while chip select is low.
- R7: Each phase length is at least one cycle, and the controller never drives the bus while the RAM may still be driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8, active high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid while rsp_done is high after a read |
| sram_addr | output | 18 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_lb_n | output | 1 | RAM low lane select, active low |
| sram_ub_n | output | 1 | RAM high lane select, active low |
| sram_dq_o | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable for the controller's bus drivers |
| sram_dq_i | input | 16 | Data read from the RAM bus |

## Verification
The assertions check the strobe combinations on every cycle. A low write strobe always comes with chip select low, output enable high and the bus driven. A low output enable never coincides with the bus driven. The drive stays off in the cycle after output enable rises and stays on in the cycle after the write strobe rises. Done never lasts two cycles, and the address never moves under a low chip select. The exact phase lengths, the turnaround that appears only after a read, the zeroing of unselected read lanes and the byte merging of partial writes can only be seen from the bench's scenarios. There, a cycle-by-cycle expected timeline and a behavioural RAM model return wrong data to an early capture and flag any bus overlap.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_READ   = 3'd1,
    SQ_TURN   = 3'd2,
    SQ_WPULSE = 3'd3,
    SQ_WEND   = 3'd4
  } sq_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(int ns, int clk_ns);
    int c;
    if (ns <= 0) return 1;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rstsync.sv
module sram_ctl_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

  // R7
  cyc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 9,
  parameter int TURN_CYC = 3,
  parameter int WR_CYC   = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_be,
  input  logic             last,
  output logic             ready,
  output logic             accept,
  output logic             capture,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic [1:0]       mask_q,
  output logic             done,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             lb_n,
  output logic             ub_n,
  output logic             dq_oe
);

  sq_state_e  state_q, state_d;
  logic       after_rd_q, after_rd_d;
  logic [1:0] mask_d;
  logic       done_d;
  logic       ce_d, oe_d, we_d, drv_d;
  logic [1:0] sel_n_d, sel_n_q;

  assign ready = (state_q == SQ_IDLE);

  // Next state, counter loads and capture strobe.
  always_comb begin
    state_d    = state_q;
    after_rd_d = after_rd_q;
    mask_d     = mask_q;
    accept     = 1'b0;
    capture    = 1'b0;
    load       = 1'b0;
    load_val   = '0;
    done_d     = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          mask_d = req_be;
          load   = 1'b1;
          if (!req_write) begin
            state_d  = SQ_READ;
            load_val = CNT_W'(RD_CYC);
          end else if (after_rd_q) begin
            state_d  = SQ_TURN;
            load_val = CNT_W'(TURN_CYC);
          end else begin
            state_d  = SQ_WPULSE;
            load_val = CNT_W'(WR_CYC);
          end
        end
      end
      SQ_READ: begin
        if (last) begin
          capture    = 1'b1;
          done_d     = 1'b1;
          after_rd_d = 1'b1;
          state_d    = SQ_IDLE;
        end
      end
      SQ_TURN: begin
        if (last) begin
          state_d  = SQ_WPULSE;
          load     = 1'b1;
          load_val = CNT_W'(WR_CYC);
        end
      end
      SQ_WPULSE: begin
        if (last) begin
          done_d     = 1'b1;
          after_rd_d = 1'b0;
          state_d    = SQ_WEND;
        end
      end
      SQ_WEND: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  // Strobe values for the coming cycle, decoded from the next state.
  always_comb begin
    ce_d    = 1'b1;
    oe_d    = 1'b1;
    we_d    = 1'b1;
    drv_d   = 1'b0;
    sel_n_d = 2'b11;
    unique case (state_d)
      SQ_READ: begin
        ce_d = 1'b0; oe_d = 1'b0; sel_n_d = ~mask_d;
      end
      SQ_TURN: begin
        ce_d = 1'b0; sel_n_d = ~mask_d;
      end
      SQ_WPULSE: begin
        ce_d = 1'b0; we_d = 1'b0; drv_d = 1'b1; sel_n_d = ~mask_d;
      end
      SQ_WEND: drv_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      after_rd_q <= 1'b0;
      mask_q     <= 2'b00;
      done       <= 1'b0;
      ce_n       <= 1'b1;
      oe_n       <= 1'b1;
      we_n       <= 1'b1;
      sel_n_q    <= 2'b11;
      dq_oe      <= 1'b0;
    end else begin
      state_q    <= state_d;
      after_rd_q <= after_rd_d;
      mask_q     <= mask_d;
      done       <= done_d;
      ce_n       <= ce_d;
      oe_n       <= oe_d;
      we_n       <= we_d;
      sel_n_q    <= sel_n_d;
      dq_oe      <= drv_d;
    end
  end

  assign lb_n = sel_n_q[0];
  assign ub_n = sel_n_q[1];

  // R4
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n && dq_oe));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe);

  // R2
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n && !dq_oe));

  // R5
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |=> !dq_oe);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        mask,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] lane_data;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_data[g*LANE_W +: LANE_W] = mask[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    addr_d  = accept  ? req_addr  : addr_q;
    wdata_d = accept  ? req_wdata : wdata_q;
    rdata_d = capture ? lane_data : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W           = 18,
  parameter int DATA_W           = 16,
  parameter int CLK_NS           = 10,
  parameter int T_ACCESS_NS      = 85,
  parameter int T_OE_ACCESS_NS   = 45,
  parameter int T_BUS_RELEASE_NS = 25,
  parameter int T_WE_PULSE_NS    = 65,
  parameter int T_ADDR_END_NS    = 75,
  parameter int T_DATA_END_NS    = 35,
  parameter int T_WR_CYCLE_NS    = 85
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int RD_CYC   = imax(ns_to_cyc(T_ACCESS_NS, CLK_NS),
                                 ns_to_cyc(T_OE_ACCESS_NS, CLK_NS));
  localparam int TURN_CYC = ns_to_cyc(T_BUS_RELEASE_NS, CLK_NS);
  localparam int WR_CYC   = imax(imax(ns_to_cyc(T_WE_PULSE_NS, CLK_NS),
                                      ns_to_cyc(T_ADDR_END_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_DATA_END_NS, CLK_NS),
                                      ns_to_cyc(T_WR_CYCLE_NS - CLK_NS, CLK_NS)));
  localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), WR_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             srst_n;
  logic             accept, capture, load, last;
  logic [CNT_W-1:0] load_val;
  logic [1:0]       mask_q;

  sram_ctl_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  sram_ctl_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WR_CYC   (WR_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .last      (last),
    .ready     (req_ready),
    .accept    (accept),
    .capture   (capture),
    .load      (load),
    .load_val  (load_val),
    .mask_q    (mask_q),
    .done      (rsp_done),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .lb_n      (sram_lb_n),
    .ub_n      (sram_ub_n),
    .dq_oe     (sram_dq_oe)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (srst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mask      (mask_q),
    .dq_i      (sram_dq_i),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_o),
    .rdata_q   (rsp_rdata)
  );

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !sram_ce_n |=> (sram_ce_n || $stable(sram_addr)));

endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

  localparam int CLK_PERIOD = 10;

  function automatic int cdiv(int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_N   = cdiv(85);
  localparam int TURN_N = cdiv(25);
  localparam int WR_N   = (cdiv(75) > cdiv(85 - CLK_PERIOD)) ? cdiv(75) : cdiv(85 - CLK_PERIOD);

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n;
  logic [15:0] sram_dq_o;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_i;

  sram_ctl #(.CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, m_checks = 0, m_fails = 0;
  bit finished = 0;

  // Expected per-cycle view: {ce_n, oe_n, we_n, lb_n, ub_n, dq_oe, done}
  typedef struct {
    logic [6:0]  ctl;
    bit          rdy;
    logic [17:0] addr;
    bit          achk;
    logic [15:0] dat;
    bit          rchk;
    string       req;
  } exp_t;

  exp_t expq[$];
  bit   cur_rdy;
  bit   prev_was_read = 0;

  function automatic logic [15:0] init_pat(logic [17:0] a);
    return a[15:0] ^ {a[17:16], 14'h1A5A};
  endfunction

  logic [15:0] shadow [int];
  logic [15:0] mem    [int];

  function automatic logic [15:0] sh_get(logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_pat(a);
  endfunction

  function automatic logic [15:0] mem_get(logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_pat(a);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  // One cycle: compare every output against the expected timeline, then release valid.
  task automatic step();
    exp_t e;
    logic [6:0] now;
    @(negedge clk);
    if (expq.size() > 0) e = expq.pop_front();
    else begin
      e.ctl = 7'b1111100; e.rdy = 1; e.addr = '0; e.achk = 0;
      e.dat = '0; e.rchk = 0; e.req = "R1";
    end
    cur_rdy = e.rdy;
    now = {sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe, rsp_done};
    chk(now == e.ctl, e.req, "strobes", 32'(now), 32'(e.ctl));
    chk(req_ready == e.rdy, e.req, "ready", 32'(req_ready), 32'(e.rdy));
    if (e.achk) chk(sram_addr == e.addr, "R6", "addr", 32'(sram_addr), 32'(e.addr));
    if (e.ctl[1]) chk(sram_dq_o == e.dat, "R4", "wdata", 32'(sram_dq_o), 32'(e.dat));
    if (e.rchk) chk(rsp_rdata == e.dat, e.req, "rdata", 32'(rsp_rdata), 32'(e.dat));
    req_valid = 1'b0;
  endtask

  task automatic push(logic [6:0] ctl, bit rdy, logic [17:0] a, bit achk,
                      logic [15:0] d, bit rchk, string req);
    exp_t e;
    e.ctl = ctl; e.rdy = rdy; e.addr = a; e.achk = achk;
    e.dat = d; e.rchk = rchk; e.req = req;
    expq.push_back(e);
  endtask

  task automatic issue(bit wr, logic [17:0] a, logic [15:0] d, logic [1:0] be);
    logic [15:0] old, expd;
    string rq;
    do step(); while (!cur_rdy);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    rq = (be == 2'b11) ? "R2" : "R3";
    old = sh_get(a);
    if (!wr) begin
      // R2: read strobes for RD_N cycles, done on the following cycle
      for (int i = 0; i < RD_N; i++)
        push({3'b001, ~be[0], ~be[1], 2'b00}, 0, a, 1, '0, 0, rq);
      expd = {be[1] ? old[15:8] : 8'h00, be[0] ? old[7:0] : 8'h00};
      push(7'b1111101, 1, a, 0, expd, 1, rq);
      prev_was_read = 1;
    end else begin
      // R5: turnaround only after a read
      if (prev_was_read)
        for (int i = 0; i < TURN_N; i++)
          push({3'b011, ~be[0], ~be[1], 2'b00}, 0, a, 1, '0, 0, "R5");
      // R4: write pulse, then end cycle with data still driven
      for (int i = 0; i < WR_N; i++)
        push({3'b010, ~be[0], ~be[1], 2'b10}, 0, a, 1, d, 0, "R4");
      push(7'b1111111, 0, a, 0, d, 0, "R4");
      shadow[int'(a)] = {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
      prev_was_read = 0;
    end
  endtask

  // Behavioural RAM: returns data only after the access time, checks bus overlap and pulse width.
  int          rd_cnt, wr_cnt, since_oe;
  logic        prev_wr, prev_oe_low;
  logic [17:0] prev_addr;
  logic [15:0] prev_d;
  logic [1:0]  prev_be;

  task automatic mchk(bit ok, string req, string what, int act, int expv);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s model %s actual=%0d expected=%0d (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    logic rd_act, wr_act;
    logic [15:0] word, cur;
    if (!rst_n) begin
      rd_cnt = 0; wr_cnt = 0; since_oe = 99; prev_wr = 0; prev_oe_low = 0;
      sram_dq_i <= 16'hBAD0;
    end else begin
      rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;
      wr_act = !sram_ce_n && !sram_we_n;
      rd_cnt = rd_act ? rd_cnt + 1 : 0;
      if (prev_oe_low && sram_oe_n) since_oe = 1;
      else if (since_oe < 99) since_oe++;
      // R5 / R7: controller drive must not overlap RAM drive
      if (sram_dq_oe) begin
        mchk(!rd_act, "R7", "drive during read", 1, 0);
        mchk((since_oe - 1) * CLK_PERIOD >= 25, "R5", "release ns", (since_oe - 1) * CLK_PERIOD, 25);
      end
      word = mem_get(sram_addr);
      if (rd_act && rd_cnt * CLK_PERIOD >= 85)
        sram_dq_i <= {sram_ub_n ? 8'hEE : word[15:8], sram_lb_n ? 8'hEE : word[7:0]};
      else
        sram_dq_i <= 16'hBAD0;
      if (wr_act) begin
        wr_cnt++;
        mchk(sram_dq_oe && sram_oe_n, "R4", "write drive", int'(sram_dq_oe), 1);
      end
      if (prev_wr && !wr_act) begin
        mchk(wr_cnt * CLK_PERIOD >= 75, "R4", "pulse ns", wr_cnt * CLK_PERIOD, 75);
        mchk(sram_dq_oe && sram_dq_o == prev_d, "R4", "data hold", int'(sram_dq_o), int'(prev_d));
        cur = mem_get(prev_addr);
        mem[int'(prev_addr)] = {prev_be[1] ? prev_d[15:8] : cur[15:8],
                                prev_be[0] ? prev_d[7:0]  : cur[7:0]};
        wr_cnt = 0;
      end
      prev_wr = wr_act; prev_addr = sram_addr; prev_d = sram_dq_o;
      prev_be = ~{sram_ub_n, sram_lb_n}; prev_oe_low = !sram_oe_n;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + m_checks, fails + m_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = 2'b00;
    // R1: idle values while reset is held
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R4: full write after reset, no turnaround
    issue(1, 18'h00010, 16'hA1B2, 2'b11);
    // R4 / R3: write after write, low lane only, no turnaround
    issue(1, 18'h00011, 16'hC3D4, 2'b01);
    // R2: full read
    issue(0, 18'h00010, '0, 2'b11);
    // R5: write right after read, high lane only
    issue(1, 18'h00010, 16'h5E00, 2'b10);
    // R3: lane reads and merged result
    issue(0, 18'h00010, '0, 2'b01);
    issue(0, 18'h00010, '0, 2'b10);
    issue(0, 18'h00011, '0, 2'b11);
    // R3: empty mask read returns zero
    issue(0, 18'h00011, '0, 2'b00);
    // R6: address extremes
    issue(1, 18'h3FFFF, 16'hFFFF, 2'b11);
    issue(1, 18'h00000, 16'h0001, 2'b11);
    issue(0, 18'h3FFFF, '0, 2'b11);
    issue(0, 18'h00000, '0, 2'b11);
    // R7: mixed traffic
    lf = 32'h00C0FFEE;
    for (int i = 0; i < 40; i++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      issue(lf[20], {lf[9:8], 12'h000, lf[3:0]}, lf[31:16], lf[13:12]);
    end
    repeat (RD_N + TURN_N + WR_N + 4) step();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + m_checks, fails + m_fails);
    $finish;
  end

endmodule